// File: doc/BRIEF.md
# Linked Display List Sequencer

This block turns a chain of four-word display descriptors, kept in a word-addressed memory, into one line descriptor per scan line of a video field. At each field start it reads two header words at a fixed location. The first is the address of the first descriptor, and zero there blanks the whole field. The second is an interrupt mask that it merges into a pending register. It then follows the chain one descriptor at a time. For every line-start strobe it hands the video path a start address, a word count, a left tab, a resolution flag, a polarity flag and a blank flag, using a valid/ready handshake.

The bitmap is stored progressively. In normal resolution, field parity picks whether the even or the odd stored lines are shown. In low resolution, every stored line is shown once in each field. When the chain ends, the sequencer pads the rest of the field with blank lines. It also does this when a pointer, base address or word count is malformed, and in that case it raises an error flag. It stops early once the field's line budget is spent.

The memory port has one read in flight at a time. The read data returns on `mem_rvalid` some cycles after a one-cycle `mem_req`.

Top module: `disp_list_seq`

States: `ST_IDLE` waits for a field start. `ST_HEAD_PTR` then `ST_HEAD_IRQ` read the two header words. `ST_DESC_NEXT`, `ST_DESC_CTRL`, `ST_DESC_BASE` and `ST_DESC_COUNT` read the four descriptor words in that order. `ST_WAIT_LINE` waits for a pending line strobe. `ST_EMIT` presents a line until it is accepted.

Transitions:
- A field start from any state goes to `ST_HEAD_PTR`.
- Each fetch state advances on its read response.
- After the mask word, or after the last line of a descriptor, the chain step runs:
  - a zero pointer goes to `ST_WAIT_LINE` in padding mode;
  - an odd pointer goes to `ST_WAIT_LINE` in padding mode with the error flag set;
  - any other pointer goes to `ST_DESC_NEXT`.
- A malformed base address or word count in `ST_DESC_BASE` goes to `ST_WAIT_LINE` in padding mode with the error flag set.
- A zero line count in `ST_DESC_COUNT` runs the chain step.
- `ST_WAIT_LINE` goes to `ST_EMIT` when a line is pending.
- In `ST_EMIT`, acceptance of the last line of the field goes to `ST_IDLE`; any other acceptance goes back to `ST_WAIT_LINE` or runs the chain step.

## Requirements
- R1: After `field_start`, the first two reads are at `HEAD_ADDR` and `HEAD_ADDR+1`. The first word is the head pointer; zero means no descriptor this field.
- R2: The word at `HEAD_ADDR+1` is ORed into `irq_pend` once per field. A bit of `irq_pend` clears only through the matching `irq_clr` bit.
- R3: A descriptor is read in order: next pointer at +0, control at +1, base address at +2, lines per field at +3. Control bit 0 = low resolution, bit 1 = inverse polarity, bits 7:2 = tab, bits 15:8 = words per line. These appear on `line_lowres`, `line_inverse`, `line_htab` and `line_words`.
- R4: In normal resolution, the first line of a descriptor has address base (even field) or base+words (odd field). Each later line adds 2*words.
- R5: In low resolution, every line of the descriptor in either field has address equal to base.
- R6: A descriptor with words per line 0 yields `line_blank`=1 lines with `line_words`=0, still counted against its line count.
- R7: After the chain ends, or when the head pointer is 0, every remaining line of the field is blank. Its `line_inverse` is the polarity of the last accepted descriptor, and this value carries across fields (0 after reset).
- R8: At most `FIELD_LINES` lines are emitted per field. Line strobes beyond that are ignored until the next field start.
- R9: An odd pointer, odd base address or odd word count sets `err_flag`, stops all further reads in the field and blanks the remaining lines. `err_flag` clears at the next `field_start`.
- R10: Exactly one line is emitted per `line_start`. While `line_valid` is high and `line_ready` low, all line outputs hold.
- R11: `mem_req` is never raised while a read is outstanding. A full descriptor costs four reads and the header costs two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| field_odd | input | 1 | Field parity, sampled with `field_start` |
| line_start | input | 1 | One-cycle pulse requesting the next line |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 16 | Read word address |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| line_valid | output | 1 | Line descriptor valid |
| line_ready | input | 1 | Line descriptor accepted |
| line_addr | output | 16 | First bitmap word of the line |
| line_words | output | 8 | Words on the line |
| line_htab | output | 6 | Left tab in 16-pixel units |
| line_lowres | output | 1 | Low-resolution line |
| line_inverse | output | 1 | White-on-black polarity |
| line_blank | output | 1 | No bitmap for this line |
| irq_clr | input | 16 | Bits to clear in `irq_pend` |
| irq_pend | output | 16 | Pending field interrupt bits |
| err_flag | output | 1 | Malformed list seen this field |

## Verification
The checker watches every cycle for the following:
- a line descriptor changing while it is stalled;
- a read request issued with one already outstanding;
- any read after the error flag is set;
- more lines than the field budget;
- pending interrupt bits dropping without a clear.

Address arithmetic across parities and resolutions, the decoding of the control word, padding polarity carried between fields, the read counts per chain, and the exact placement of the error stop can only be shown by the bench's scenarios. These compare each emitted line against a model of the list walk.

// File: rtl/dls_pkg.sv
package dls_pkg;
    localparam int WORD_W  = 16;
    localparam int WORDS_W = 8;
    localparam int TAB_W   = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD_PTR,
        ST_HEAD_IRQ,
        ST_DESC_NEXT,
        ST_DESC_CTRL,
        ST_DESC_BASE,
        ST_DESC_COUNT,
        ST_WAIT_LINE,
        ST_EMIT
    } seq_state_e;
endpackage

// File: rtl/dls_line_addr.sv
module dls_line_addr
    import dls_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               advance,
    input  logic [WORD_W-1:0]  base,
    input  logic [WORDS_W-1:0] words,
    input  logic               lowres,
    input  logic               odd,
    output logic [WORD_W-1:0]  addr
);
    localparam int PAD_W = WORD_W - WORDS_W;

    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] first_ofs;

    always_comb begin
        first_ofs = (odd && !lowres) ? {{PAD_W{1'b0}}, words} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            step <= '0;
        end else if (load) begin
            addr <= base + first_ofs;
            step <= lowres ? '0 : {{(PAD_W-1){1'b0}}, words, 1'b0};
        end else if (advance) begin
            addr <= addr + step;
        end
    end
endmodule

// File: rtl/dls_irq_acc.sv
module dls_irq_acc
    import dls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              merge,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] clr,
    output logic [WORD_W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | (merge ? mask : '0);
        end
    end
endmodule

// File: rtl/disp_list_seq.sv
module disp_list_seq
    import dls_pkg::*;
#(
    parameter logic [15:0] HEAD_ADDR   = 16'h0110,
    parameter int          FIELD_LINES = 262
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_start,
    input  logic               field_odd,
    input  logic               line_start,
    output logic               mem_req,
    output logic [WORD_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_rvalid,
    output logic               line_valid,
    input  logic               line_ready,
    output logic [WORD_W-1:0]  line_addr,
    output logic [WORDS_W-1:0] line_words,
    output logic [TAB_W-1:0]   line_htab,
    output logic               line_lowres,
    output logic               line_inverse,
    output logic               line_blank,
    input  logic [WORD_W-1:0]  irq_clr,
    output logic [WORD_W-1:0]  irq_pend,
    output logic               err_flag
);
    localparam int CNT_W = $clog2(FIELD_LINES + 1);
    localparam logic [CNT_W-1:0] LAST_LINE = CNT_W'(FIELD_LINES - 1);

    seq_state_e state, state_nx;

    logic [WORD_W-1:0] nxt, ptr, ctrl, rem;
    logic [CNT_W-1:0]  line_cnt;
    logic tail, pol, rd_busy, pend, odd_r;
    logic rd_done, fetching;
    logic chain, set_err, set_tail, ld_addr, step, accept, irq_merge;

    assign rd_done  = mem_rvalid && rd_busy;
    assign fetching = (state == ST_HEAD_PTR) || (state == ST_HEAD_IRQ) ||
                      (state == ST_DESC_NEXT) || (state == ST_DESC_CTRL) ||
                      (state == ST_DESC_BASE) || (state == ST_DESC_COUNT);

    // next state and strobes
    always_comb begin
        state_nx  = state;
        chain     = 1'b0;
        set_err   = 1'b0;
        set_tail  = 1'b0;
        ld_addr   = 1'b0;
        step      = 1'b0;
        accept    = 1'b0;
        irq_merge = 1'b0;
        if (field_start) begin
            state_nx = ST_HEAD_PTR;
        end else begin
            unique case (state)
                ST_IDLE:       state_nx = ST_IDLE;
                ST_HEAD_PTR:   if (rd_done) state_nx = ST_HEAD_IRQ;
                ST_HEAD_IRQ:   if (rd_done) begin
                                   irq_merge = 1'b1;
                                   chain     = 1'b1;
                               end
                ST_DESC_NEXT:  if (rd_done) state_nx = ST_DESC_CTRL;
                ST_DESC_CTRL:  if (rd_done) state_nx = ST_DESC_BASE;
                ST_DESC_BASE:  if (rd_done) begin
                                   if (mem_rdata[0] || ctrl[8]) begin
                                       set_err  = 1'b1;
                                       set_tail = 1'b1;
                                       state_nx = ST_WAIT_LINE;
                                   end else begin
                                       ld_addr  = 1'b1;
                                       state_nx = ST_DESC_COUNT;
                                   end
                               end
                ST_DESC_COUNT: if (rd_done) begin
                                   if (mem_rdata == '0) chain = 1'b1;
                                   else state_nx = ST_WAIT_LINE;
                               end
                ST_WAIT_LINE:  if (pend) state_nx = ST_EMIT;
                ST_EMIT:       if (line_ready) begin
                                   accept = 1'b1;
                                   if (line_cnt == LAST_LINE) begin
                                       state_nx = ST_IDLE;
                                   end else if (tail) begin
                                       state_nx = ST_WAIT_LINE;
                                   end else begin
                                       step = 1'b1;
                                       if (rem == 16'd1) chain = 1'b1;
                                       else state_nx = ST_WAIT_LINE;
                                   end
                               end
                default:       state_nx = ST_IDLE;
            endcase
            if (chain) begin
                if (nxt == '0) begin
                    set_tail = 1'b1;
                    state_nx = ST_WAIT_LINE;
                end else if (nxt[0]) begin
                    set_err  = 1'b1;
                    set_tail = 1'b1;
                    state_nx = ST_WAIT_LINE;
                end else begin
                    state_nx = ST_DESC_NEXT;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // list walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt <= '0; ptr <= '0; ctrl <= '0; rem <= '0;
            line_cnt <= '0; tail <= 1'b0; pol <= 1'b0;
            err_flag <= 1'b0; rd_busy <= 1'b0; pend <= 1'b0; odd_r <= 1'b0;
        end else if (field_start) begin
            line_cnt <= '0; tail <= 1'b0; err_flag <= 1'b0;
            rd_busy  <= 1'b0; pend <= 1'b0; odd_r <= field_odd;
        end else begin
            if (mem_req)         rd_busy <= 1'b1;
            else if (mem_rvalid) rd_busy <= 1'b0;
            if (line_start)                                pend <= 1'b1;
            else if (state == ST_WAIT_LINE && pend)        pend <= 1'b0;
            if (rd_done) begin
                if (state == ST_HEAD_PTR || state == ST_DESC_NEXT) nxt <= mem_rdata;
                if (state == ST_DESC_CTRL) ctrl <= mem_rdata;
                if (state == ST_DESC_COUNT) begin
                    rem <= mem_rdata;
                    pol <= ctrl[1];
                end
            end
            if (chain && state_nx == ST_DESC_NEXT) ptr <= nxt;
            if (set_err)  err_flag <= 1'b1;
            if (set_tail) tail <= 1'b1;
            if (accept)   line_cnt <= line_cnt + 1'b1;
            if (step)     rem <= rem - 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_req = fetching && !rd_busy && !field_start;
        unique case (state)
            ST_HEAD_PTR:   mem_addr = HEAD_ADDR;
            ST_HEAD_IRQ:   mem_addr = HEAD_ADDR + 16'd1;
            ST_DESC_CTRL:  mem_addr = ptr + 16'd1;
            ST_DESC_BASE:  mem_addr = ptr + 16'd2;
            ST_DESC_COUNT: mem_addr = ptr + 16'd3;
            default:       mem_addr = ptr;
        endcase
        line_valid   = (state == ST_EMIT);
        line_words   = tail ? '0 : ctrl[15:8];
        line_htab    = tail ? '0 : ctrl[7:2];
        line_lowres  = tail ? 1'b0 : ctrl[0];
        line_inverse = pol;
        line_blank   = tail || (ctrl[15:8] == '0);
    end

    dls_line_addr u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_addr),
        .advance (step),
        .base    (mem_rdata),
        .words   (ctrl[15:8]),
        .lowres  (ctrl[0]),
        .odd     (odd_r),
        .addr    (line_addr)
    );

    dls_irq_acc u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .merge (irq_merge),
        .mask  (mem_rdata),
        .clr   (irq_clr),
        .pend  (irq_pend)
    );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int FIELD_LINES = 262
) (
    input logic        clk,
    input logic        rst_n,
    input logic        field_start,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        line_valid,
    input logic        line_ready,
    input logic [15:0] line_addr,
    input logic [7:0]  line_words,
    input logic        line_inverse,
    input logic        line_blank,
    input logic [15:0] irq_clr,
    input logic [15:0] irq_pend,
    input logic        err_flag
);
    localparam int CW = $clog2(FIELD_LINES + 1) + 1;

    logic          outstanding;
    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            seen        <= '0;
        end else begin
            if (mem_req)         outstanding <= 1'b1;
            else if (mem_rvalid) outstanding <= 1'b0;
            if (field_start)                    seen <= '0;
            else if (line_valid && line_ready)  seen <= seen + 1'b1;
        end
    end

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ready && !field_start |=> line_valid && $stable(line_addr) &&
        $stable(line_words) && $stable(line_inverse) && $stable(line_blank)); // R10

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outstanding); // R11

    AST_NO_READ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !field_start |-> !mem_req); // R9

    AST_LINE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> seen < CW'(FIELD_LINES)); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr == 16'h0 |=> (irq_pend & $past(irq_pend)) == $past(irq_pend)); // R2
endmodule

bind disp_list_seq dls_checker #(.FIELD_LINES(FIELD_LINES)) u_dls_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_start  (field_start),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .line_valid   (line_valid),
    .line_ready   (line_ready),
    .line_addr    (line_addr),
    .line_words   (line_words),
    .line_inverse (line_inverse),
    .line_blank   (line_blank),
    .irq_clr      (irq_clr),
    .irq_pend     (irq_pend),
    .err_flag     (err_flag)
);

// File: tb/tb_disp_list_seq.sv
module tb_disp_list_seq;
    localparam logic [15:0] HEAD = 16'h0010;
    localparam int FL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_start = 1'b0, field_odd = 1'b0, line_start = 1'b0;
    logic mem_req, mem_rvalid;
    logic [15:0] mem_addr, mem_rdata;
    logic line_valid, line_ready, line_lowres, line_inverse, line_blank, err_flag;
    logic [15:0] line_addr, irq_pend;
    logic [15:0] irq_clr = 16'h0;
    logic [7:0] line_words;
    logic [5:0] line_htab;

    always #5 clk = ~clk;

    disp_list_seq #(.HEAD_ADDR(HEAD), .FIELD_LINES(FL)) dut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
        .line_start(line_start), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .line_valid(line_valid),
        .line_ready(line_ready), .line_addr(line_addr), .line_words(line_words),
        .line_htab(line_htab), .line_lowres(line_lowres), .line_inverse(line_inverse),
        .line_blank(line_blank), .irq_clr(irq_clr), .irq_pend(irq_pend), .err_flag(err_flag)
    );

    // memory model, two-cycle read latency
    logic [15:0] bm [0:63];
    logic v1 = 1'b0, v2 = 1'b0;
    logic [15:0] a1 = '0, d2 = '0;
    always @(posedge clk) begin
        v1 <= mem_req;
        a1 <= mem_addr;
        v2 <= v1;
        d2 <= bm[a1[5:0]];
    end
    assign mem_rvalid = v2;
    assign mem_rdata  = d2;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  words;
        logic [5:0]  htab;
        logic        lowres;
        logic        inv;
        logic        blank;
    } line_t;

    line_t       exp_q [$];
    logic [15:0] req_q [$];
    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit stall = 0;
    int stall_cnt = 0;
    string tag = "R4";
    logic [15:0] irq_exp = '0;
    bit pol_last = 0;
    bit e_err;
    int e_reads;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // ready driver
    always @(posedge clk) begin
        #1;
        stall_cnt = stall_cnt + 1;
        line_ready = stall ? (stall_cnt % 3 == 0) : 1'b1;
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                req_q.push_back(mem_addr);
                if (err_flag) check(0, "R9", "read after error", 1, 0);
            end
            if (line_valid && line_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "line beyond budget", 1, 0);
                end else begin
                    line_t e;
                    e = exp_q.pop_front();
                    check(line_blank == e.blank, "R6", "blank", line_blank, e.blank);
                    check(line_inverse == e.inv, "R7", "polarity", line_inverse, e.inv);
                    check(line_words == e.words, "R3", "words", line_words, e.words);
                    if (!e.blank) begin
                        check(line_addr == e.addr, tag, "address", line_addr, e.addr);
                        check(line_htab == e.htab, "R3", "tab", line_htab, e.htab);
                        check(line_lowres == e.lowres, "R3", "lowres", line_lowres, e.lowres);
                    end
                end
            end
        end
    end

    // model of one field's list walk
    task automatic build(bit odd);
        logic [15:0] p, nx, c, sa, sl;
        int n;
        line_t it;
        n = 0;
        e_err = 0;
        e_reads = 2;
        p = bm[HEAD[5:0]];
        irq_exp = irq_exp | bm[HEAD[5:0] + 1];
        if (p[0]) e_err = 1;
        while (!e_err && p != 0 && n < FL) begin
            nx = bm[p[5:0]];
            c  = bm[p[5:0] + 1];
            sa = bm[p[5:0] + 2];
            sl = bm[p[5:0] + 3];
            if (sa[0] || c[8]) begin
                e_err = 1;
                e_reads += 3;
                break;
            end
            e_reads += 4;
            pol_last = c[1];
            for (int i = 0; i < int'(sl) && n < FL; i++) begin
                it.words  = c[15:8];
                it.htab   = c[7:2];
                it.lowres = c[0];
                it.inv    = c[1];
                it.blank  = (c[15:8] == 0);
                it.addr   = c[0] ? sa :
                            16'(sa + (odd ? {8'h0, c[15:8]} : 16'h0) + 16'(2 * i) * {8'h0, c[15:8]});
                exp_q.push_back(it);
                n++;
            end
            p = nx;
            if (n < FL && p[0]) e_err = 1;
        end
        while (n < FL) begin
            it = '0;
            it.inv = pol_last;
            it.blank = 1'b1;
            exp_q.push_back(it);
            n++;
        end
    endtask

    task automatic run_field(bit odd, int nlines, string t);
        tag = t;
        req_q.delete();
        build(odd);
        @(negedge clk);
        field_start = 1'b1;
        field_odd = odd;
        @(negedge clk);
        field_start = 1'b0;
        for (int l = 0; l < nlines; l++) begin
            repeat (25) @(negedge clk);
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
        end
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R10", "lines missing", exp_q.size(), 0);
        exp_q.delete();
        check(err_flag == e_err, "R9", "error flag", err_flag, e_err);
        check(irq_pend == irq_exp, "R2", "irq pending", irq_pend, irq_exp);
        check(req_q.size() == e_reads, "R11", "read count", req_q.size(), e_reads);
        if (req_q.size() >= 2) begin
            check(req_q[0] == HEAD, "R1", "head read", req_q[0], HEAD);
            check(req_q[1] == HEAD + 1, "R1", "mask read", req_q[1], HEAD + 1);
        end
    endtask

    task automatic put_desc(int at, logic [15:0] nx, logic [15:0] c, logic [15:0] sa, logic [15:0] sl);
        bm[at] = nx; bm[at+1] = c; bm[at+2] = sa; bm[at+3] = sl;
    endtask

    initial begin
        line_ready = 1'b1;
        for (int i = 0; i < 64; i++) bm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_valid == 0, "R10", "reset valid", line_valid, 0);
        check(mem_req == 0, "R11", "reset req", mem_req, 0);
        check(err_flag == 0, "R9", "reset err", err_flag, 0);
        check(irq_pend == 0, "R2", "reset irq", irq_pend, 0);

        // normal resolution, both parities, blank descriptor, end padding
        bm[HEAD] = 16'h0020; bm[HEAD+1] = 16'h0003;
        put_desc(16'h20, 16'h0028, 16'h0416, 16'h1000, 16'd2);
        put_desc(16'h28, 16'h0000, 16'h000E, 16'h2000, 16'd1);
        run_field(0, FL, "R4");
        bm[HEAD+1] = 16'h0000;
        run_field(1, FL, "R4");

        // low resolution with stalled consumer
        put_desc(16'h20, 16'h0028, 16'h0417, 16'h1000, 16'd3);
        stall = 1;
        run_field(1, FL, "R5");
        stall = 0;

        // display off: all blank, polarity carried
        bm[HEAD] = 16'h0000; bm[HEAD+1] = 16'h0100;
        run_field(0, FL, "R7");
        @(negedge clk);
        irq_clr = 16'h0001;
        @(negedge clk);
        irq_clr = 16'h0000;
        irq_exp = irq_exp & ~16'h0001;
        @(negedge clk);
        check(irq_pend == irq_exp, "R2", "irq after clear", irq_pend, irq_exp);

        // field budget with extra strobes
        bm[HEAD] = 16'h0020; bm[HEAD+1] = 16'h0000;
        put_desc(16'h20, 16'h0028, 16'h0414, 16'h3000, 16'd10);
        run_field(0, FL + 2, "R8");

        // odd base address
        put_desc(16'h20, 16'h0028, 16'h0416, 16'h1001, 16'd2);
        run_field(0, FL, "R9");

        // odd next pointer
        put_desc(16'h20, 16'h0029, 16'h0416, 16'h1000, 16'd1);
        run_field(1, FL, "R9");

        // error clears on the next field
        bm[HEAD] = 16'h0000;
        run_field(0, FL, "R7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule